// File: doc/BRIEF.md
# Masked Dual Interrupt Status Unit

This block keeps the status word of a memory-card host controller and turns it into two interrupt lines. The low status bits are sticky event flags. The command and data engines raise them with one-cycle set pulses, and software clears them by writing ones to a clear register. The upper status bits are not stored. They show live level inputs that report activity and FIFO fill state.

Each interrupt line has its own 32-bit enable mask. A line is high whenever any status bit is set in both the status word and that line's mask. So one status word can feed two interrupt controllers with different selections.

A simple register port gives access to the two masks, the status word, the clear register and eight read-only identification bytes. The read data is a combinational decode of the address. A read changes no state.

Top module: `irq_status_unit`

## Requirements
- R1: Reset clears all stored event bits and both mask registers to zero, so the status word reads zero when the flag inputs are low and both interrupt lines are low.
- R2: A one on `ev_set[b]`, for b in 0..8 or 10, sets status bit b at the next clock edge. The bit stays set until it is cleared. The event bits are: 0 command CRC error, 1 data CRC error, 2 command timeout, 3 data timeout, 4 transmit underrun, 5 receive overrun, 6 response received, 7 command sent, 8 data end, 10 block end.
- R3: A write to offset 0x38 clears each status bit in 10:0 whose written data bit is 1. Written bits 31:11 have no effect.
- R4: When a set pulse and a clear write hit the same bit in the same cycle, the bit ends up set.
- R5: Status bits 21:11 follow `flag_lvl[10:0]` in the same cycle, and a clear write does not change them. The flags are: command active, transmit active, receive active, transmit half empty, receive half full, transmit full, receive full, transmit empty, receive empty, transmit data available, receive data available.
- R6: Status bit 9 and bits 31:22 always read zero, and `ev_set[9]` is ignored.
- R7: Offsets 0x3C and 0x40 are the masks for lines 0 and 1. Each is a read/write register of all 32 bits.
- R8: `irq_out[i]` is 1 exactly when the status word AND mask i is nonzero. It follows the status word and the masks without added delay.
- R9: Reads of offsets 0xFE0 to 0xFFC return one identification byte per word, in this order: 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R10: The status word reads at offset 0x34. Undefined offsets read zero. Writes to the status word, the identification words or undefined offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_set | input | 11 | One-cycle set pulses for event bits 10:0 |
| flag_lvl | input | 11 | Live activity and FIFO levels shown as status bits 21:11 |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write enable, valid with bus_sel |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_out | output | 2 | Masked interrupt lines 0 and 1 |

## Verification
The assertions check the event bits on every cycle. A set pulse must land. A clear write with no pulse must take effect. Without either, the bits must hold, bit 9 must stay zero, and the interrupt lines must stay low while no status bit is active.

Some behaviour only the bench scenarios show. These are how the two masks select different bits for each line, the priority of a set over a clear in one cycle, and that the live flags survive a clear. They also cover the identification bytes, the silent writes to read-only offsets and the return to zero after a second reset.

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int NUM_EVT  = 11,
  parameter int NUM_FLAG = 11,
  parameter int NUM_IRQ  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EVT-1:0]  ev_set,
  input  logic [NUM_FLAG-1:0] flag_lvl,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_IRQ-1:0] irq_out
);
  localparam int STAT_W = NUM_EVT + NUM_FLAG;
  localparam logic [NUM_EVT-1:0] EVT_VALID = ~(NUM_EVT'(1) << 9);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'('h34);
  localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'('h38);
  localparam logic [ADDR_W-1:0] A_MASK0 = ADDR_W'('h3C);
  localparam logic [ADDR_W-1:0] A_IDLO  = ADDR_W'('hFE0);

  logic [NUM_EVT-1:0] evt_q;
  logic [DATA_W-1:0]  mask_q [NUM_IRQ];
  logic [DATA_W-1:0]  status_w;
  logic               wr;
  logic [NUM_EVT-1:0] clr_bits;

  function automatic logic [7:0] id_byte(input logic [2:0] k);
    case (k)
      3'd0: id_byte = 8'h81;
      3'd1: id_byte = 8'h11;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

  assign wr       = bus_sel & bus_we;
  assign clr_bits = (wr && bus_addr == A_CLR) ? bus_wdata[NUM_EVT-1:0] : '0;
  assign status_w = {{(DATA_W-STAT_W){1'b0}}, flag_lvl, evt_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= ((evt_q & ~clr_bits) | ev_set) & EVT_VALID;
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    localparam logic [ADDR_W-1:0] A_MASK = A_MASK0 + ADDR_W'(4 * i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        mask_q[i] <= '0;
      else if (wr && bus_addr == A_MASK) mask_q[i] <= bus_wdata;
    end
    assign irq_out[i] = |(status_w & mask_q[i]);
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_STAT) bus_rdata = status_w;
    for (int i = 0; i < NUM_IRQ; i++)
      if (bus_addr == A_MASK0 + ADDR_W'(4 * i)) bus_rdata = mask_q[i];
    if (bus_addr >= A_IDLO && bus_addr[1:0] == 2'b00)
      bus_rdata = DATA_W'(id_byte(bus_addr[4:2]));
  end
endmodule

module irq_status_chk #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int NUM_EVT = 11,
  parameter int NUM_FLAG = 11,
  parameter int NUM_IRQ = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_EVT-1:0]  ev_set,
  input logic [NUM_FLAG-1:0] flag_lvl,
  input logic                bus_sel,
  input logic                bus_we,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [NUM_EVT-1:0]  evt_q,
  input logic [NUM_IRQ-1:0]  irq_out
);
  localparam logic [NUM_EVT-1:0] VALID = ~(NUM_EVT'(1) << 9);
  logic clr_wr;
  assign clr_wr = bus_sel && bus_we && bus_addr == ADDR_W'('h38);

  // R2
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_set & VALID) != 0 |=> (evt_q & $past(ev_set & VALID)) == $past(ev_set & VALID));

  // R3
  clear_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr && ev_set == 0 |=> (evt_q & $past(bus_wdata[NUM_EVT-1:0])) == 0);

  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr && ev_set == 0 |=> $stable(evt_q));

  // R6
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q[9] == 1'b0);

  // R8
  quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q == 0 && flag_lvl == 0 |-> irq_out == 0);
endmodule

bind irq_status_unit irq_status_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_EVT(NUM_EVT), .NUM_FLAG(NUM_FLAG), .NUM_IRQ(NUM_IRQ)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_set(ev_set), .flag_lvl(flag_lvl),
  .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .evt_q(evt_q), .irq_out(irq_out)
);

// File: tb/test_irq_status_unit.sv
`timescale 1ns/1ps
module test_irq_status_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [10:0] ev_set = '0;
  logic [10:0] flag_lvl = '0;
  logic        bus_sel = 0, bus_we = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq_out;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  irq_status_unit i_irq_status_unit (
    .clk(clk), .rst_n(rst_n), .ev_set(ev_set), .flag_lvl(flag_lvl),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  // {offset, expected read value}: identification bytes (R9) and holes (R10)
  localparam logic [43:0] RD_TAB [12] = '{
    {12'hFE0, 32'h81}, {12'hFE4, 32'h11}, {12'hFE8, 32'h04}, {12'hFEC, 32'h00},
    {12'hFF0, 32'h0D}, {12'hFF4, 32'hF0}, {12'hFF8, 32'h05}, {12'hFFC, 32'hB1},
    {12'h000, 32'h0},  {12'h044, 32'h0},  {12'h080, 32'h0},  {12'hFE2, 32'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic pulse(input logic [10:0] e);
    @(negedge clk); ev_set = e;
    @(negedge clk); ev_set = '0;
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(12'h034, v); chk("R1 status", v, 0);
    rd(12'h03C, v); chk("R1 mask0", v, 0);
    rd(12'h040, v); chk("R1 mask1", v, 0);
    chk("R1 irq", 32'(irq_out), 0);

    for (int i = 0; i < 12; i++) begin
      rd(RD_TAB[i][43:32], v);
      chk(i < 8 ? "R9 id byte" : "R10 hole", v, RD_TAB[i][31:0]);
    end

    wr(12'h03C, 32'hA5A5_0F0F); rd(12'h03C, v); chk("R7 mask0", v, 32'hA5A5_0F0F);
    wr(12'h040, 32'hFFFF_FFFF); rd(12'h040, v); chk("R7 mask1", v, 32'hFFFF_FFFF);
    wr(12'h03C, 0); wr(12'h040, 0);

    pulse(11'h001);
    rd(12'h034, v); chk("R2 set bit0", v, 32'h1);
    chk("R8 masked off", 32'(irq_out), 0);
    wr(12'h03C, 32'h1);
    chk("R8 line0 only", 32'(irq_out), 32'h1);
    wr(12'h040, 32'h0010_0000);
    chk("R8 line1 idle", 32'(irq_out), 32'h1);
    @(negedge clk); flag_lvl = 11'h200; #1;
    rd(12'h034, v); chk("R5 flag bit20", v, 32'h0010_0001);
    chk("R8 both lines", 32'(irq_out), 32'h3);
    @(negedge clk); flag_lvl = '0; #1;
    chk("R8 line1 drops", 32'(irq_out), 32'h1);

    wr(12'h038, 32'hFFFF_F800);
    rd(12'h034, v); chk("R3 high clear bits ignored", v, 32'h1);
    wr(12'h038, 32'h1);
    rd(12'h034, v); chk("R3 clear bit0", v, 0);
    chk("R8 after clear", 32'(irq_out), 0);

    pulse(11'h7FF);
    rd(12'h034, v); chk("R6 bit9 stays zero", v, 32'h5FF);
    wr(12'h038, 32'h0F0);
    rd(12'h034, v); chk("R3 partial clear", v, 32'h50F);

    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = 12'h038;
    bus_wdata = 32'h00F; ev_set = 11'h002;
    @(negedge clk); bus_sel = 0; bus_we = 0; ev_set = '0;
    rd(12'h034, v); chk("R4 set beats clear", v, 32'h502);

    wr(12'h034, 32'h0);
    rd(12'h034, v); chk("R10 status write ignored", v, 32'h502);
    wr(12'hFE0, 32'hDEAD);
    rd(12'hFE0, v); chk("R10 id write ignored", v, 32'h81);
    wr(12'h100, 32'hFFFF_FFFF);
    rd(12'h100, v); chk("R10 hole write ignored", v, 0);

    @(negedge clk); flag_lvl = 11'h7FF; #1;
    rd(12'h034, v); chk("R5 all flags", v, 32'h003F_FD02);
    wr(12'h038, 32'hFFFF_FFFF);
    rd(12'h034, v); chk("R5 flags survive clear", v, 32'h003F_F800);

    @(negedge clk); flag_lvl = '0; rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd(12'h034, v); chk("R1 status after reset", v, 0);
    rd(12'h03C, v); chk("R1 mask0 after reset", v, 0);
    chk("R1 irq after reset", 32'(irq_out), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule